// File: doc/BRIEF.md
# Masked Bit Test-and-Modify Unit

This unit takes one 16-bit data word together with an 8-bit mask and checks the bits the mask selects. It reports whether those bits are all ones or all zeros. Two of its operations also set or clear the selected bits and hand back the changed word for write-back. A 2-bit placement code decides where the 8-bit mask sits in the 16-bit word: the upper byte, the lower byte or both bytes. A word read from a short register (6 or 8 bits wide) is sign-extended to 16 bits before it is tested.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, one register stage later. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or its result is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is accepted. The producer may keep `in_valid` raised during that time. The write-back strobe `out_wr` qualifies `out_word` and is only meaningful while `out_valid` is high.

Top module: `bitop_unit`

## Requirements
- R1: Placement code 00 puts the mask in bits 15:8 of the 16-bit mask and zeros in bits 7:0.
- R2: Placement code 01 puts zeros in bits 15:8 and the mask in bits 7:0.
- R3: Placement codes 10 and 11 both copy the mask into bits 15:8 and into bits 7:0.
- R4: Op code 01 (test-high) drives `out_flag` to 1 exactly when every selected bit of the operand is 1.
- R5: Op code 00 (test-low) drives `out_flag` to 1 exactly when every selected bit of the operand is 0.
- R6: Op code 10 (test-high then set) returns the operand OR the 16-bit mask on `out_word`, with `out_wr` = 1. Its `out_flag` is the test-high result.
- R7: Op code 11 (test-low then clear) returns the operand AND the inverted mask on `out_word`, with `out_wr` = 1. Its `out_flag` is the test-low result.
- R8: For op codes 10 and 11, `out_flag` is computed on the operand before it is modified.
- R9: Op codes 00 and 01 keep `out_wr` at 0 and return the operand unmodified on `out_word`. `out_wr` is never 1 while `out_valid` is 0.
- R10: When `in_short` is 1, the operand is the data word sign-extended from bit 5 (`in_w8` = 0) or from bit 7 (`in_w8` = 1). When `in_short` is 0, the data word is used as is.
- R11: An all-zero mask makes both tests report 1 and leaves the word unchanged under set and clear.
- R12: A request accepted at a clock edge shows its result on the outputs right after that edge. While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the outputs hold.
- R13: During and after reset, `out_valid` and `out_wr` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_mask | input | 8 | 8-bit mask |
| in_place | input | 2 | Mask placement: 00 upper, 01 lower, 10/11 both |
| in_op | input | 2 | 00 test-low, 01 test-high, 10 test-high+set, 11 test-low+clear |
| in_data | input | 16 | Data word |
| in_short | input | 1 | Data comes from a short register |
| in_w8 | input | 1 | Short-register width: 0 = 6 bits, 1 = 8 bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_flag | output | 1 | Test outcome |
| out_word | output | 16 | Processed word |
| out_wr | output | 1 | Write-back strobe for out_word |

## Verification
Every result is due one clock edge after its request is accepted. The bench drives each request on a falling edge and lets the next rising edge accept it. It reads the outputs on the following falling edge, midway between edges. The back-pressure scenario holds `out_ready` low across several edges while a second request waits. At each falling edge it checks that the first result has not moved and that `in_ready` stays low. It then releases the stall and checks that the waiting request appears exactly one edge later and that the output empties one edge after that.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    PL_UPPER    = 2'b00,
    PL_LOWER    = 2'b01,
    PL_BOTH     = 2'b10,
    PL_BOTH_ALT = 2'b11
  } place_e;

  typedef enum logic [1:0] {
    OP_TST_LO     = 2'b00,
    OP_TST_HI     = 2'b01,
    OP_TST_HI_SET = 2'b10,
    OP_TST_LO_CLR = 2'b11
  } op_e;
endpackage

// File: rtl/bitop_mask_expand.sv
module bitop_mask_expand
  import bitop_pkg::*;
#(
  parameter int MASK_W = 8,
  localparam int WORD_W = 2 * MASK_W
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [1:0]        place,
  output logic [WORD_W-1:0] mask_full
);
  always_comb begin
    unique case (place_e'(place))
      PL_UPPER: mask_full = {mask, {MASK_W{1'b0}}};
      PL_LOWER: mask_full = {{MASK_W{1'b0}}, mask};
      default:  mask_full = {mask, mask};
    endcase
  end
endmodule

// File: rtl/bitop_sign_ext.sv
module bitop_sign_ext #(
  parameter int WORD_W   = 16,
  parameter int NARROW_A = 6,
  parameter int NARROW_B = 8
) (
  input  logic [WORD_W-1:0] data,
  input  logic              is_short,
  input  logic              wide_sel,
  output logic [WORD_W-1:0] operand
);
  localparam int SEL_W = $clog2(WORD_W);
  logic [SEL_W-1:0] top_idx;
  logic             top_bit;

  assign top_idx = wide_sel ? SEL_W'(NARROW_B - 1) : SEL_W'(NARROW_A - 1);
  assign top_bit = data[top_idx];

  always_comb begin
    operand = data;
    if (is_short) begin
      for (int i = 0; i < WORD_W; i++) begin
        if (i > int'(top_idx)) operand[i] = top_bit;
      end
    end
  end
endmodule

// File: rtl/bitop_core.sv
module bitop_core
  import bitop_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] operand,
  input  logic [WORD_W-1:0] mask_full,
  input  logic [1:0]        op,
  output logic              flag,
  output logic              wr,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] picked;
  logic              all_high;
  logic              all_low;

  assign picked   = operand & mask_full;
  assign all_high = (picked == mask_full);
  assign all_low  = (picked == '0);

  always_comb begin
    unique case (op_e'(op))
      OP_TST_LO: begin
        flag = all_low;  wr = 1'b0; word = operand;
      end
      OP_TST_HI: begin
        flag = all_high; wr = 1'b0; word = operand;
      end
      OP_TST_HI_SET: begin
        flag = all_high; wr = 1'b1; word = operand | mask_full;
      end
      default: begin
        flag = all_low;  wr = 1'b1; word = operand & ~mask_full;
      end
    endcase
  end
endmodule

// File: rtl/bitop_out_reg.sv
module bitop_out_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              nx_flag,
  input  logic              nx_wr,
  input  logic [WORD_W-1:0] nx_word,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_flag,
  output logic              dn_wr,
  output logic [WORD_W-1:0] dn_word
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_flag  <= 1'b0;
      dn_wr    <= 1'b0;
      dn_word  <= '0;
    end else if (take) begin
      dn_valid <= 1'b1;
      dn_flag  <= nx_flag;
      dn_wr    <= nx_wr;
      dn_word  <= nx_word;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
      dn_wr    <= 1'b0;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_word) && $stable(dn_flag) && $stable(dn_wr)));

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dn_valid);

  assert_wr_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_wr |-> dn_valid);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int MASK_W   = 8,
  parameter int NARROW_A = 6,
  parameter int NARROW_B = 8,
  localparam int WORD_W  = 2 * MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [1:0]        in_place,
  input  logic [1:0]        in_op,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_short,
  input  logic              in_w8,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_flag,
  output logic [WORD_W-1:0] out_word,
  output logic              out_wr
);
  logic [WORD_W-1:0] mask_full;
  logic [WORD_W-1:0] operand;
  logic              c_flag;
  logic              c_wr;
  logic [WORD_W-1:0] c_word;

  bitop_mask_expand #(.MASK_W(MASK_W)) u_mask (
    .mask(in_mask), .place(in_place), .mask_full(mask_full)
  );

  bitop_sign_ext #(.WORD_W(WORD_W), .NARROW_A(NARROW_A), .NARROW_B(NARROW_B)) u_ext (
    .data(in_data), .is_short(in_short), .wide_sel(in_w8), .operand(operand)
  );

  bitop_core #(.WORD_W(WORD_W)) u_core (
    .operand(operand), .mask_full(mask_full), .op(in_op),
    .flag(c_flag), .wr(c_wr), .word(c_word)
  );

  bitop_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready),
    .nx_flag(c_flag), .nx_wr(c_wr), .nx_word(c_word),
    .dn_valid(out_valid), .dn_ready(out_ready),
    .dn_flag(out_flag), .dn_wr(out_wr), .dn_word(out_word)
  );

  logic acc;
  assign acc = in_valid && in_ready;

  assert_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_place[1]) |-> ($countones(mask_full) == 2 * $countones(in_mask)));

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_TST_HI_SET) |=> (out_wr && ((out_word & $past(mask_full)) == $past(mask_full))));

  assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_TST_LO_CLR) |=> (out_wr && ((out_word & $past(mask_full)) == '0)));

  assert_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_op[1]) |=> (!out_wr && out_word == $past(operand)));
endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_mask = '0;
  logic [1:0]  in_place = '0;
  logic [1:0]  in_op = '0;
  logic [15:0] in_data = '0;
  logic        in_short = 1'b0;
  logic        in_w8 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_flag;
  logic [15:0] out_word;
  logic        out_wr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_place(in_place), .in_op(in_op),
    .in_data(in_data), .in_short(in_short), .in_w8(in_w8),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_flag(out_flag), .out_word(out_word), .out_wr(out_wr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One request with out_ready high; result read one edge later.
  task automatic xact(input string tag, input logic [7:0] m, input logic [1:0] pl,
                      input logic [1:0] op, input logic [15:0] d, input logic sh,
                      input logic w8, input logic ef, input logic [15:0] ew, input logic ewr);
    @(negedge clk);
    in_valid = 1'b1; in_mask = m; in_place = pl; in_op = op;
    in_data = d; in_short = sh; in_w8 = w8;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, 16'(out_valid), 16'd1);
    chk({tag, " flag"}, 16'(out_flag), 16'(ef));
    chk({tag, " word"}, out_word, ew);
    chk({tag, " wr"}, 16'(out_wr), 16'(ewr));
  endtask

  task automatic t_reset;
    chk("R13 valid", 16'(out_valid), 16'd0);
    chk("R13 wr", 16'(out_wr), 16'd0);
    chk("R13 ready", 16'(in_ready), 16'd1);
  endtask

  task automatic t_place;
    xact("R1 upper", 8'h0F, 2'b00, 2'b10, 16'h0000, 0, 0, 1'b0, 16'h0F00, 1'b1);
    xact("R2 lower", 8'h0F, 2'b01, 2'b10, 16'h0000, 0, 0, 1'b0, 16'h000F, 1'b1);
    xact("R3 both10", 8'h0F, 2'b10, 2'b10, 16'h0000, 0, 0, 1'b0, 16'h0F0F, 1'b1);
    xact("R3 both11", 8'h0F, 2'b11, 2'b10, 16'h0000, 0, 0, 1'b0, 16'h0F0F, 1'b1);
  endtask

  task automatic t_tests;
    xact("R4 hi true", 8'h0F, 2'b10, 2'b01, 16'h0F0F, 0, 0, 1'b1, 16'h0F0F, 1'b0);
    xact("R4 hi false", 8'h0F, 2'b10, 2'b01, 16'h0F0E, 0, 0, 1'b0, 16'h0F0E, 1'b0);
    xact("R5 lo true", 8'hF0, 2'b01, 2'b00, 16'h000F, 0, 0, 1'b1, 16'h000F, 1'b0);
    xact("R5 lo false", 8'hF0, 2'b01, 2'b00, 16'h001F, 0, 0, 1'b0, 16'h001F, 1'b0);
    xact("R9 hi upper", 8'hA5, 2'b00, 2'b01, 16'hA4FF, 0, 0, 1'b0, 16'hA4FF, 1'b0);
  endtask

  task automatic t_modify;
    xact("R6 set", 8'h81, 2'b01, 2'b10, 16'h1200, 0, 0, 1'b0, 16'h1281, 1'b1);
    xact("R8 set already", 8'h81, 2'b01, 2'b10, 16'h1281, 0, 0, 1'b1, 16'h1281, 1'b1);
    xact("R7 clr", 8'hFF, 2'b00, 2'b11, 16'h1234, 0, 0, 1'b0, 16'h0034, 1'b1);
    xact("R8 clr already", 8'hFF, 2'b00, 2'b11, 16'h0034, 0, 0, 1'b1, 16'h0034, 1'b1);
  endtask

  task automatic t_short;
    xact("R10 w6 neg", 8'h80, 2'b00, 2'b01, 16'h0020, 1, 0, 1'b1, 16'hFFE0, 1'b0);
    xact("R10 w8 neg", 8'h80, 2'b00, 2'b01, 16'h0080, 1, 1, 1'b1, 16'hFF80, 1'b0);
    xact("R10 w8 pos", 8'h80, 2'b00, 2'b00, 16'h007F, 1, 1, 1'b1, 16'h007F, 1'b0);
    xact("R10 w6 junk", 8'hFF, 2'b00, 2'b00, 16'hAB1F, 1, 0, 1'b1, 16'h001F, 1'b0);
    xact("R10 long", 8'hFF, 2'b00, 2'b01, 16'hAB1F, 0, 0, 1'b0, 16'hAB1F, 1'b0);
  endtask

  task automatic t_zero;
    xact("R11 hi", 8'h00, 2'b10, 2'b01, 16'h5A5A, 0, 0, 1'b1, 16'h5A5A, 1'b0);
    xact("R11 lo", 8'h00, 2'b10, 2'b00, 16'h5A5A, 0, 0, 1'b1, 16'h5A5A, 1'b0);
    xact("R11 set", 8'h00, 2'b10, 2'b10, 16'h5A5A, 0, 0, 1'b1, 16'h5A5A, 1'b1);
    xact("R11 clr", 8'h00, 2'b10, 2'b11, 16'h5A5A, 0, 0, 1'b1, 16'h5A5A, 1'b1);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_mask = 8'h01; in_place = 2'b01; in_op = 2'b10;
    in_data = 16'h0000; in_short = 1'b0; in_w8 = 1'b0;
    @(negedge clk);
    chk("R12 first valid", 16'(out_valid), 16'd1);
    chk("R12 first word", out_word, 16'h0001);
    chk("R12 ready low", 16'(in_ready), 16'd0);
    in_mask = 8'h02;
    repeat (2) @(negedge clk);
    chk("R12 held word", out_word, 16'h0001);
    chk("R12 held valid", 16'(out_valid), 16'd1);
    chk("R12 still blocked", 16'(in_ready), 16'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 second valid", 16'(out_valid), 16'd1);
    chk("R12 second word", out_word, 16'h0002);
    @(negedge clk);
    chk("R12 drained", 16'(out_valid), 16'd0);
    chk("R13 wr idle", 16'(out_wr), 16'd0);
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'd1, 16'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_place();
    t_tests();
    t_modify();
    t_short();
    t_zero();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule